// File: doc/BRIEF.md
# Host-Loaded 3x3 Colour Matrix Multiplier

This block applies a programmable 3x3 matrix to three pixel channels sampled at the same rate. It is typically used for colour-space conversion. Each cycle it can accept one triple of signed fixed-point samples. It then produces three unsigned 8-bit results, and each result is the sum of three coefficient-times-sample products. The products, the sum and the rounding each sit in their own register stage. A valid flag runs beside the data through the same number of registers.

A host loads the nine coefficients over a byte-wide data bus and a 5-bit address bus, and can read them back. The host side is synchronous to the pixel clock and uses single-cycle strobes qualified by a select. Each 12-bit coefficient occupies two byte addresses. The low byte is held in a per-coefficient staging register. The coefficient seen by the datapath changes only when its high byte is written, so a half-written coefficient never reaches the multipliers.

Top module: `cmx_matrix3`

## Requirements
- R1: out_a = c1·a + c2·b + c3·c, out_b = c4·a + c5·b + c6·c and out_c = c7·a + c8·b + c9·c, where a, b and c are the samples on in_a, in_b and in_c.
- R2: Coefficients are 12-bit two's complement with 9 fractional bits, covering -4.0 to +2047/512 in steps of 1/512. Samples are 13-bit two's complement with 3 fractional bits.
- R3: The exact sum, which has 12 fractional bits, is rounded to an integer by adding one half and taking the floor, so ties go toward positive.
- R4: The rounded value is clamped to 0..255. A negative value gives 0, and any value above 255 gives 255.
- R5: A sample triple taken at a rising edge with in_valid high appears on the outputs with out_valid high after the fourth rising edge, counting the sampling edge. out_valid always equals in_valid delayed by four cycles.
- R6: Coefficient ck (k = 1..9) has its low byte (bits 7:0) at address 2(k-1) and its high byte (bits 11:8 in data bits 3:0) at address 2(k-1)+1. Host strobes have effect only while host_cs is high.
- R7: Writing a low byte only stages it and does not change the coefficient used by the datapath or read back. Writing the high byte loads {high bits, staged low byte} in one step.
- R8: Data bits 7:4 of a high-byte write are ignored. A read of a high byte returns zero in bits 7:4. These bits are not sign bits.
- R9: A read strobe loads host_rdata at the next rising edge with the addressed byte of the active coefficient. host_rdata holds its value between reads.
- R10: Addresses 18 to 31 are unmapped. Writes to them change nothing, and reads from them return 0.
- R11: Synchronous active-high rst clears all coefficients, staged bytes, pipeline registers, out_valid and host_rdata to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| host_cs | input | 1 | Host select, qualifies both strobes |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_addr | input | 5 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| in_valid | input | 1 | Input sample triple is valid |
| in_a | input | 13 | Channel A sample, signed, 3 fractional bits |
| in_b | input | 13 | Channel B sample, signed, 3 fractional bits |
| in_c | input | 13 | Channel C sample, signed, 3 fractional bits |
| out_valid | output | 1 | Output triple is valid |
| out_a | output | 8 | Result for row 1, unsigned |
| out_b | output | 8 | Result for row 2, unsigned |
| out_c | output | 8 | Result for row 3, unsigned |

## Verification
A pixel result is due after the fourth rising edge following the edge that samples its inputs. Each expected triple therefore enters the scoreboard stamped with the cycle in which it was driven. The monitor pops it only on out_valid and checks both the three values and that exactly four cycles have elapsed. Read data is due one edge after the read strobe and is sampled at the following falling edge. Coefficients are changed only after the pipeline has drained, so every expected value uses one well-defined coefficient set.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

    localparam int COEF_W    = 12;
    localparam int COEF_FRAC = 9;
    localparam int PIX_W     = 13;
    localparam int PIX_FRAC  = 3;
    localparam int OUT_W     = 8;
    localparam int N_IN      = 3;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int PIPE_LAT  = 4;

    localparam int N_COEF    = N_IN * N_IN;
    localparam int HI_W      = COEF_W - BYTE_W;
    localparam int PROD_W    = COEF_W + PIX_W;
    localparam int SUM_W     = PROD_W + $clog2(N_IN);
    localparam int SHIFT     = COEF_FRAC + PIX_FRAC;
    localparam int OUT_MAX   = (1 << OUT_W) - 1;

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PIX_W-1:0]  pix_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic [OUT_W-1:0]         out_t;
    typedef logic [BYTE_W-1:0]        byte_t;
    typedef logic [ADDR_W-1:0]        addr_t;

    // smallest exact sum that rounds to a value above the output range
    localparam sum_t SAT_HI_TH = sum_t'((OUT_MAX << SHIFT) + (1 << (SHIFT - 1)));
    localparam logic signed [SUM_W:0] RND_HALF = (SUM_W + 1)'(1) << (SHIFT - 1);

    // add one half, floor to integer, clamp to output range
    function automatic out_t round_sat(input sum_t s);
        logic signed [SUM_W:0]       r;
        logic signed [SUM_W-SHIFT:0] q;
        r = {s[SUM_W-1], s} + RND_HALF;
        q = r[SUM_W:SHIFT];
        if (q < 0)
            return '0;
        else if (int'(q) > OUT_MAX)
            return out_t'(OUT_MAX);
        else
            return q[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/cmx_coef_bank.sv
module cmx_coef_bank
    import cmx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_cs,
    input  logic  host_wr,
    input  logic  host_rd,
    input  addr_t host_addr,
    input  byte_t host_wdata,
    output byte_t host_rdata,
    output coef_t coef_o [N_COEF]
);

    logic [N_COEF-1:0] wr_lo;
    logic [N_COEF-1:0] wr_hi;
    byte_t             stage_q [N_COEF];
    coef_t             coef_q  [N_COEF];
    byte_t             rd_mux;
    logic              past_ok;

    for (genvar k = 0; k < N_COEF; k++) begin : g_coef
        assign wr_lo[k] = host_cs && host_wr && (host_addr == addr_t'(2 * k));
        assign wr_hi[k] = host_cs && host_wr && (host_addr == addr_t'(2 * k + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[k] <= '0;
                coef_q[k]  <= '0;
            end else begin
                if (wr_lo[k])
                    stage_q[k] <= host_wdata;
                if (wr_hi[k])
                    coef_q[k] <= coef_t'({host_wdata[HI_W-1:0], stage_q[k]});
            end
        end

        assign coef_o[k] = coef_q[k];

        // R7
        coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_hi[k] |=> $stable(coef_q[k]));
    end

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < N_COEF; k++) begin
            if (host_addr == addr_t'(2 * k))
                rd_mux = coef_q[k][BYTE_W-1:0];
            else if (host_addr == addr_t'(2 * k + 1))
                rd_mux = byte_t'(coef_q[k][COEF_W-1:BYTE_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (host_cs && host_rd)
            host_rdata <= rd_mux;
    end

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R8
    hi_nibble_zero_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(host_cs && host_rd && host_addr[0] && (host_addr < addr_t'(2 * N_COEF)))
        |-> host_rdata[BYTE_W-1:HI_W] == '0);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(host_cs && host_rd && (host_addr >= addr_t'(2 * N_COEF)))
        |-> host_rdata == '0);

endmodule

// File: rtl/cmx_row_mac.sv
module cmx_row_mac
    import cmx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  coef_t k_i [N_IN],
    input  pix_t  x_i [N_IN],
    output out_t  y_o
);

    prod_t prod_q [N_IN];
    sum_t  sum_d;
    sum_t  sum_q;
    logic  past_ok;

    for (genvar i = 0; i < N_IN; i++) begin : g_mul
        always_ff @(posedge clk) begin
            if (rst) prod_q[i] <= '0;
            else     prod_q[i] <= prod_t'(k_i[i]) * prod_t'(x_i[i]);
        end
    end

    always_comb begin
        sum_d = '0;
        for (int i = 0; i < N_IN; i++)
            sum_d = sum_d + sum_t'(prod_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= '0;
            y_o     <= '0;
            past_ok <= 1'b0;
        end else begin
            sum_q   <= sum_d;
            y_o     <= round_sat(sum_q);
            past_ok <= 1'b1;
        end
    end

    // R4
    sat_low_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(sum_q < 0) |-> y_o == '0);

    // R4
    sat_high_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(sum_q >= SAT_HI_TH) |-> y_o == out_t'(OUT_MAX));

endmodule

// File: rtl/cmx_matrix3.sv
module cmx_matrix3
    import cmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                host_cs,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [BYTE_W-1:0]   host_wdata,
    output logic [BYTE_W-1:0]   host_rdata,
    input  logic                in_valid,
    input  logic [PIX_W-1:0]    in_a,
    input  logic [PIX_W-1:0]    in_b,
    input  logic [PIX_W-1:0]    in_c,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_a,
    output logic [OUT_W-1:0]    out_b,
    output logic [OUT_W-1:0]    out_c
);

    coef_t                coef [N_COEF];
    pix_t                 pix_d [N_IN];
    pix_t                 pix_q [N_IN];
    out_t                 y [N_IN];
    logic [PIPE_LAT-1:0]  vld_q;
    logic [2:0]           age_q;

    cmx_coef_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .host_cs    (host_cs),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .coef_o     (coef)
    );

    assign pix_d[0] = in_a;
    assign pix_d[1] = in_b;
    assign pix_d[2] = in_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_IN; i++) pix_q[i] <= '0;
            vld_q <= '0;
        end else begin
            for (int i = 0; i < N_IN; i++) pix_q[i] <= pix_d[i];
            vld_q <= {vld_q[PIPE_LAT-2:0], in_valid};
        end
    end

    for (genvar r = 0; r < N_IN; r++) begin : g_row
        coef_t row_k [N_IN];
        for (genvar i = 0; i < N_IN; i++) begin : g_sel
            assign row_k[i] = coef[r * N_IN + i];
        end
        cmx_row_mac u_row (
            .clk (clk),
            .rst (rst),
            .k_i (row_k),
            .x_i (pix_q),
            .y_o (y[r])
        );
    end

    assign out_a     = y[0];
    assign out_b     = y[1];
    assign out_c     = y[2];
    assign out_valid = vld_q[PIPE_LAT-1];

    always_ff @(posedge clk) begin
        if (rst)                         age_q <= '0;
        else if (age_q < 3'(PIPE_LAT))   age_q <= age_q + 3'd1;
    end

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q == 3'(PIPE_LAT)) |-> out_valid == $past(in_valid, 4));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && host_rdata == '0 && out_a == '0));

endmodule

// File: tb/sim_cmx_matrix3.sv
`timescale 1ns/1ps
module sim_cmx_matrix3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        in_valid = 1'b0;
    logic [12:0] in_a = '0, in_b = '0, in_c = '0;
    logic        out_valid;
    logic [7:0]  out_a, out_b, out_c;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 1'b0;
    int mc [9];
    int ms [9];
    int q_a[$], q_b[$], q_c[$], q_cyc[$];
    string q_tag[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    cmx_matrix3 u0 (
        .clk(clk), .rst(rst), .host_cs(host_cs), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model(input int k0, input int k1, input int k2,
                                 input int a, input int b, input int c);
        int s, r;
        s = k0 * a + k1 * b + k2 * c;
        r = (s + 2048) >>> 12;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    task automatic host_write(input int addr, input int data, input bit cs = 1'b1);
        host_cs = cs; host_wr = 1'b1; host_addr = 5'(addr); host_wdata = 8'(data);
        @(negedge clk);
        host_cs = 1'b0; host_wr = 1'b0;
        if (cs && addr < 18) begin
            if (addr % 2 == 0) ms[addr/2] = data & 255;
            else begin
                mc[addr/2] = ((data & 15) << 8) | ms[addr/2];
                if (mc[addr/2] >= 2048) mc[addr/2] -= 4096;
            end
        end
    endtask

    task automatic host_read(input int addr, input int exp, input string tag);
        host_cs = 1'b1; host_rd = 1'b1; host_addr = 5'(addr);
        @(negedge clk);
        host_cs = 1'b0; host_rd = 1'b0;
        chk(host_rdata == 8'(exp), tag, int'(host_rdata), exp);
    endtask

    function automatic int coef_byte(input int addr);
        if (addr >= 18) return 0;
        if (addr % 2 == 0) return mc[addr/2] & 255;
        return (mc[addr/2] >> 8) & 15;
    endfunction

    task automatic set_coef(input int k, input int v);
        host_write(2*k, v & 255);
        host_write(2*k + 1, (v >> 8) & 15);
    endtask

    task automatic push(input int a, input int b, input int c, input string tag);
        in_valid = 1'b1; in_a = 13'(a); in_b = 13'(b); in_c = 13'(c);
        q_a.push_back(model(mc[0], mc[1], mc[2], a, b, c));
        q_b.push_back(model(mc[3], mc[4], mc[5], a, b, c));
        q_c.push_back(model(mc[6], mc[7], mc[8], a, b, c));
        q_cyc.push_back(cyc);
        q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops one expected triple per valid output
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_a.size() == 0) begin
                chk(1'b0, "R5 unexpected out_valid", 1, 0);
            end else begin
                int ea, eb, ec, ecy;
                string t;
                ea = q_a.pop_front(); eb = q_b.pop_front(); ec = q_c.pop_front();
                ecy = q_cyc.pop_front(); t = q_tag.pop_front();
                chk(cyc == ecy + 4, {t, " R5 latency"}, cyc - ecy, 4);
                chk(out_a == 8'(ea), {t, " out_a"}, int'(out_a), ea);
                chk(out_b == 8'(eb), {t, " out_b"}, int'(out_b), eb);
                chk(out_c == 8'(ec), {t, " out_c"}, int'(out_c), ec);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ident [9];
        int mat [9];
        for (int k = 0; k < 9; k++) begin mc[k] = 0; ms[k] = 0; end
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
        chk(out_a == 0 && out_b == 0 && out_c == 0, "R11 outputs after reset", int'(out_a), 0);
        host_read(1, 0, "R11 c1 high after reset");
        host_read(16, 0, "R11 c9 low after reset");

        // R1 identity matrix
        ident = '{512, 0, 0, 0, 512, 0, 0, 0, 512};
        for (int k = 0; k < 9; k++) set_coef(k, ident[k]);
        push(100*8, 50*8, 200*8, "R1 identity");
        push(7*8, 255*8, 0, "R1 identity b");
        idle(6);

        // R1 R2 R6 general signed matrix, streaming with gaps
        mat = '{256, 128, -64, -512, 768, 384, 1024, -256, 64};
        for (int k = 0; k < 9; k++) set_coef(k, mat[k]);
        for (int k = 0; k < 18; k++) host_read(k, coef_byte(k), "R6 R9 coefficient readback");
        for (int i = 0; i < 12; i++) begin
            push(((i * 389) % 2048) - 300, ((i * 211) % 1800), ((i * 97) % 1500) - 200, "R1 R2 stream");
            if (i % 3 == 2) idle(1);
        end
        idle(6);

        // R2 extreme coefficients
        set_coef(0, -2048);
        set_coef(1, 2047);
        set_coef(2, 0);
        push(-8*20, 8*30, 0, "R2 extreme coefficients");
        idle(6);

        // R3 rounding ties toward positive
        for (int k = 0; k < 9; k++) set_coef(k, ident[k]);
        push(8*10 + 4, 8*10 + 3, 8*10 + 5, "R3 rounding");
        push(8*3 + 4, 8*0 + 4, 8*254 + 4, "R3 rounding b");
        idle(6);

        // R4 saturation both sides
        push(8*300, -8*5, 4095, "R4 saturation");
        push(-4096, 8*256, -1, "R4 saturation b");
        idle(6);

        // R7 low byte alone is staged only
        host_write(0, 0);
        push(8*40, 0, 0, "R7 staged low byte not active");
        idle(6);
        host_read(0, 0, "R7 low readback still active value");
        host_write(1, 1);
        host_read(0, 0, "R7 commit readback low");
        host_read(1, 1, "R7 commit readback high");
        push(8*40, 0, 0, "R7 committed coefficient");
        idle(6);

        // R8 upper nibble ignored on write, zero on read
        host_write(8, 8'h00);
        host_write(9, 8'hF8);
        host_read(9, 8, "R8 high nibble reads zero");
        chk(mc[4] == -2048, "R8 bit 11 is the sign", mc[4], -2048);
        push(0, -8*16, 0, "R8 nibble write effect");
        idle(6);

        // R10 unmapped addresses
        host_write(20, 8'h5A);
        host_write(31, 8'hA5);
        host_read(20, 0, "R10 unmapped read");
        host_read(18, 0, "R10 unmapped read 18");
        host_read(8, coef_byte(8), "R10 mapped byte unchanged");
        host_read(9, coef_byte(9), "R10 mapped high unchanged");

        // R6 strobes without select have no effect
        host_write(1, 8'h07, 1'b0);
        host_read(1, coef_byte(1), "R6 write without select ignored");
        host_rd = 1'b1; host_addr = 5'd9;
        @(negedge clk);
        host_rd = 1'b0;
        chk(host_rdata == 8'(coef_byte(1)), "R9 rdata held without select", int'(host_rdata), coef_byte(1));

        // R11 reset clears coefficients
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 9; k++) begin mc[k] = 0; ms[k] = 0; end
        host_read(1, 0, "R11 c1 high cleared");
        host_read(8, 0, "R11 c5 low cleared");
        push(8*100, 8*100, 8*100, "R11 zero coefficients");
        idle(6);

        chk(q_a.size() == 0, "R5 scoreboard drained", q_a.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule